// File: doc/BRIEF.md
# Mailbox Host Interrupt Mask Controller

This block drives the level-sensitive interrupt that a mailbox presents to its host. It keeps a small mask register with two live bits, an enable and a pending flag. It also keeps the three handshake flags that decide when an interrupt is due: controller-to-host attention, SMS attention and controller busy. The host writes the mask register to arm, disarm and acknowledge the interrupt. The management controller side signals that a response is ready, raises or drops SMS attention, and announces resets. The flags are shown on output ports so that the surrounding register interface can present them. Message transfer is handled elsewhere.

The pending bit can be set in three ways. A response-ready event sets it. An SMS attention that turns on sets it, but only while no controller-to-host attention is already outstanding. A host write that turns the enable on while either attention flag is set also sets it, after the fact. The interrupt line is a registered copy of the pending bit and appears one cycle after it. When the `HAS_IRQ` parameter is zero, there is no interrupt line: the output stays low and the response and SMS paths never set pending.

Every event in a cycle is seen by the next clock edge, in a fixed order. First the host clears of attention flags take effect. Then the mask write is applied, then the response-ready event, then the SMS request, and last the reset indication. Each step sees the result of the steps before it.

Top module: `mbx_irq_mask_ctrl`

## Requirements
- R1: After reset, the mask read value is zero, the interrupt is low and all three flags are clear. In the read value, bit 0 is the enable, bit 1 is pending, and all other bits read zero.
- R2: A mask write whose bit 0 turns the enable from 0 to 1 sets pending if either attention flag was set before that cycle. This does not depend on the global enable. If neither flag was set, pending is left clear.
- R3: A mask write whose bit 0 turns the enable from 1 to 0 clears pending. Writing the same enable value that is already held changes neither bit.
- R4: A mask write with bit 1 at 1 clears pending when it is set. When pending is already clear, such a write has no effect.
- R5: A response-ready pulse clears busy and sets controller-to-host attention. It sets pending only when the line exists, the global enable is 1, the enable bit is 1 and pending is clear. A host doorbell pulse sets busy.
- R6: A request to set SMS attention has no effect when SMS attention is already set. When SMS attention turns on, pending is set only if the request asks for an interrupt, the line exists, the global and mask enables are 1, and controller-to-host attention is clear.
- R7: When SMS attention turns off while controller-to-host attention is clear, pending is cleared. While controller-to-host attention is set, pending is kept.
- R8: A reset indication with the cold flag clears both enable and pending. Without the cold flag, it leaves them unchanged.
- R9: The interrupt output equals the pending bit one clock later.
- R10: Host clear pulses for the two attention flags clear those flags and leave enable and pending unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mask_wr | input | 1 | Host write strobe for the mask register |
| mask_wdata | input | 2 | Written bits: bit 0 enable, bit 1 acknowledge |
| glob_irq_en | input | 1 | Global interrupt enable |
| host_doorbell | input | 1 | Host signals a request; sets busy |
| host_clr_c2h | input | 1 | Host clears controller-to-host attention |
| host_clr_sms | input | 1 | Host clears SMS attention |
| rsp_ready | input | 1 | Controller response is ready |
| sms_set_req | input | 1 | Controller asks to set SMS attention |
| sms_clr_req | input | 1 | Controller asks to clear SMS attention |
| sms_irq_req | input | 1 | With a set request: interrupt wanted |
| ctl_reset | input | 1 | Reset indication pulse |
| ctl_reset_cold | input | 1 | Qualifies ctl_reset as cold |
| mask_rdata | output | REG_W | Mask register read value |
| c2h_atn | output | 1 | Controller-to-host attention flag |
| sms_atn | output | 1 | SMS attention flag |
| ctl_busy | output | 1 | Controller busy flag |
| host_irq | output | 1 | Level interrupt to host |

## Verification
The hardest case to reach is an SMS set or clear that arrives while controller-to-host attention is already outstanding, with the pending bit in a chosen state. Reaching it requires building a chain of steps: a response-ready pulse first, then a host acknowledge or a second response, and only then the SMS request. The stimulus walks that chain one step at a time. After each edge it checks pending, the interrupt line and the flags. It repeats the clear on both sides of the controller-to-host flag, so that both the suppression rule and the retention rule are exercised.

// File: rtl/mbx_irq_pkg.sv
package mbx_irq_pkg;
  localparam int unsigned EN_BIT   = 0;
  localparam int unsigned PEND_BIT = 1;

  typedef struct packed {
    logic c2h;
    logic sms;
    logic busy;
  } atn_flags_t;

  typedef struct packed {
    logic en;
    logic pend;
  } mask_state_t;
endpackage

// File: rtl/mbx_atn_flags.sv
module mbx_atn_flags
  import mbx_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       host_doorbell,
  input  logic       host_clr_c2h,
  input  logic       host_clr_sms,
  input  logic       rsp_ready,
  input  logic       sms_set_req,
  input  logic       sms_clr_req,
  output atn_flags_t flags_q,
  output logic       c2h_mid,
  output logic       sms_rise,
  output logic       sms_fall
);
  atn_flags_t flags_d;
  logic       c2h_base;
  logic       sms_base;

  // Host clears act first; controller events are applied on top.
  always_comb begin
    c2h_base = flags_q.c2h & ~host_clr_c2h;
    sms_base = flags_q.sms & ~host_clr_sms;
    c2h_mid  = c2h_base | rsp_ready;
    sms_rise = sms_set_req & ~sms_base;
    sms_fall = sms_clr_req & ~sms_set_req & sms_base;

    flags_d.c2h = c2h_mid;
    if (sms_rise) begin
      flags_d.sms = 1'b1;
    end else if (sms_fall) begin
      flags_d.sms = 1'b0;
    end else begin
      flags_d.sms = sms_base;
    end
    if (rsp_ready) begin
      flags_d.busy = 1'b0;
    end else if (host_doorbell) begin
      flags_d.busy = 1'b1;
    end else begin
      flags_d.busy = flags_q.busy;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
    end else begin
      flags_q <= flags_d;
    end
  end

  // R5: response ready leaves attention set and busy clear
  a_r5_rsp_flags: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ready |=> (flags_q.c2h && !flags_q.busy));

  // R6: a set request always leaves SMS attention set
  a_r6_sms_set: assert property (@(posedge clk) disable iff (!rst_n)
    sms_set_req |=> flags_q.sms);
endmodule

// File: rtl/mbx_mask_ctrl.sv
module mbx_mask_ctrl
  import mbx_irq_pkg::*;
#(
  parameter bit HAS_IRQ = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        mask_wr,
  input  logic [1:0]  mask_wdata,
  input  logic        glob_irq_en,
  input  logic        rsp_ready,
  input  logic        c2h_now,
  input  logic        sms_now,
  input  logic        c2h_mid,
  input  logic        sms_rise,
  input  logic        sms_fall,
  input  logic        sms_irq_req,
  input  logic        ctl_reset,
  input  logic        ctl_reset_cold,
  output mask_state_t mask_q
);
  localparam logic LINE_OK = HAS_IRQ;

  mask_state_t mask_d;
  logic        irq_gate;

  assign irq_gate = LINE_OK & glob_irq_en;

  always_comb begin
    mask_d = mask_q;
    // host write: enable edge handling, then acknowledge
    if (mask_wr) begin
      if (mask_wdata[EN_BIT] != mask_q.en) begin
        if (mask_wdata[EN_BIT]) begin
          if (c2h_now || sms_now) begin
            mask_d.pend = 1'b1;
          end
          mask_d.en = 1'b1;
        end else begin
          mask_d.pend = 1'b0;
          mask_d.en   = 1'b0;
        end
      end
      if (mask_wdata[PEND_BIT] && mask_d.pend) begin
        mask_d.pend = 1'b0;
      end
    end
    // response ready
    if (rsp_ready && irq_gate && mask_d.en && !mask_d.pend) begin
      mask_d.pend = 1'b1;
    end
    // SMS attention edges
    if (sms_rise && sms_irq_req && irq_gate && mask_d.en && !c2h_mid) begin
      mask_d.pend = 1'b1;
    end
    if (sms_fall && !c2h_mid && mask_d.pend) begin
      mask_d.pend = 1'b0;
    end
    // cold reset wins over everything
    if (ctl_reset && ctl_reset_cold) begin
      mask_d.pend = 1'b0;
      mask_d.en   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else begin
      mask_q <= mask_d;
    end
  end

  // R3: pending can only be held while enabled
  a_r3_pend_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    mask_q.pend |-> mask_q.en);

  // R3: writing enable low leaves pending clear
  a_r3_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_wr && !mask_wdata[EN_BIT]) |=> !mask_q.pend);

  // R4: acknowledge without a simultaneous source clears pending
  a_r4_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_wr && mask_wdata[PEND_BIT] && !rsp_ready && !sms_rise) |=> !mask_q.pend);

  // R8: cold reset empties the mask register
  a_r8_cold_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_reset && ctl_reset_cold) |=> (!mask_q.en && !mask_q.pend));
endmodule

// File: rtl/mbx_irq_line.sv
module mbx_irq_line #(
  parameter bit HAS_IRQ = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pend,
  output logic irq
);
  generate
    if (HAS_IRQ) begin : g_line
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          irq_q <= 1'b0;
        end else begin
          irq_q <= pend;
        end
      end
      assign irq = irq_q;

      // R9: line follows pending with one cycle of delay
      a_r9_line_follows: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend) |=> irq);
    end else begin : g_noline
      logic unused_pend;
      assign unused_pend = pend;
      assign irq = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/mbx_irq_mask_ctrl.sv
module mbx_irq_mask_ctrl
  import mbx_irq_pkg::*;
#(
  parameter int unsigned REG_W   = 8,
  parameter bit          HAS_IRQ = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mask_wr,
  input  logic [1:0]       mask_wdata,
  input  logic             glob_irq_en,
  input  logic             host_doorbell,
  input  logic             host_clr_c2h,
  input  logic             host_clr_sms,
  input  logic             rsp_ready,
  input  logic             sms_set_req,
  input  logic             sms_clr_req,
  input  logic             sms_irq_req,
  input  logic             ctl_reset,
  input  logic             ctl_reset_cold,
  output logic [REG_W-1:0] mask_rdata,
  output logic             c2h_atn,
  output logic             sms_atn,
  output logic             ctl_busy,
  output logic             host_irq
);
  atn_flags_t  flags_q;
  mask_state_t mask_q;
  logic        c2h_mid;
  logic        sms_rise;
  logic        sms_fall;

  mbx_atn_flags u_flags (
    .clk           (clk),
    .rst_n         (rst_n),
    .host_doorbell (host_doorbell),
    .host_clr_c2h  (host_clr_c2h),
    .host_clr_sms  (host_clr_sms),
    .rsp_ready     (rsp_ready),
    .sms_set_req   (sms_set_req),
    .sms_clr_req   (sms_clr_req),
    .flags_q       (flags_q),
    .c2h_mid       (c2h_mid),
    .sms_rise      (sms_rise),
    .sms_fall      (sms_fall)
  );

  mbx_mask_ctrl #(.HAS_IRQ(HAS_IRQ)) u_mask (
    .clk            (clk),
    .rst_n          (rst_n),
    .mask_wr        (mask_wr),
    .mask_wdata     (mask_wdata),
    .glob_irq_en    (glob_irq_en),
    .rsp_ready      (rsp_ready),
    .c2h_now        (flags_q.c2h),
    .sms_now        (flags_q.sms),
    .c2h_mid        (c2h_mid),
    .sms_rise       (sms_rise),
    .sms_fall       (sms_fall),
    .sms_irq_req    (sms_irq_req),
    .ctl_reset      (ctl_reset),
    .ctl_reset_cold (ctl_reset_cold),
    .mask_q         (mask_q)
  );

  mbx_irq_line #(.HAS_IRQ(HAS_IRQ)) u_line (
    .clk   (clk),
    .rst_n (rst_n),
    .pend  (mask_q.pend),
    .irq   (host_irq)
  );

  always_comb begin
    mask_rdata           = '0;
    mask_rdata[EN_BIT]   = mask_q.en;
    mask_rdata[PEND_BIT] = mask_q.pend;
  end

  assign c2h_atn  = flags_q.c2h;
  assign sms_atn  = flags_q.sms;
  assign ctl_busy = flags_q.busy;

  // R10: host clear alone does not disturb the mask bits
  a_r10_clr_keeps_mask: assert property (@(posedge clk) disable iff (!rst_n)
    ((host_clr_c2h || host_clr_sms) && !mask_wr && !rsp_ready && !sms_set_req
     && !sms_clr_req && !ctl_reset) |=> $stable(mask_q));
endmodule

// File: tb/mbx_irq_mask_ctrl_test.sv
`timescale 1ns/1ps
module mbx_irq_mask_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       mask_wr, glob_irq_en, host_doorbell, host_clr_c2h, host_clr_sms;
  logic [1:0] mask_wdata;
  logic       rsp_ready, sms_set_req, sms_clr_req, sms_irq_req, ctl_reset, ctl_reset_cold;
  logic [7:0] mask_rdata;
  logic       c2h_atn, sms_atn, ctl_busy, host_irq;

  always #2.5 clk = ~clk;

  mbx_irq_mask_ctrl uut (
    .clk(clk), .rst_n(rst_n), .mask_wr(mask_wr), .mask_wdata(mask_wdata),
    .glob_irq_en(glob_irq_en), .host_doorbell(host_doorbell),
    .host_clr_c2h(host_clr_c2h), .host_clr_sms(host_clr_sms),
    .rsp_ready(rsp_ready), .sms_set_req(sms_set_req), .sms_clr_req(sms_clr_req),
    .sms_irq_req(sms_irq_req), .ctl_reset(ctl_reset), .ctl_reset_cold(ctl_reset_cold),
    .mask_rdata(mask_rdata), .c2h_atn(c2h_atn), .sms_atn(sms_atn),
    .ctl_busy(ctl_busy), .host_irq(host_irq)
  );

  typedef struct {
    logic [7:0] rd;
    logic       irq;
    logic       c2h;
    logic       sms;
    logic       busy;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_checks = 0;
  int   n_errors = 0;
  bit   done = 0;

  // reference state
  logic m_en, m_pend, m_c2h, m_sms, m_busy;

  task automatic idle_inputs();
    mask_wr = 0; mask_wdata = 2'b00; host_doorbell = 0; host_clr_c2h = 0;
    host_clr_sms = 0; rsp_ready = 0; sms_set_req = 0; sms_clr_req = 0;
    sms_irq_req = 0; ctl_reset = 0; ctl_reset_cold = 0;
  endtask

  task automatic model_step();
    logic c2h0, sms0, c2hm, smsb, rise, fall;
    c2h0 = m_c2h; sms0 = m_sms;
    if (mask_wr) begin
      if (mask_wdata[0] && !m_en) begin
        if (c2h0 || sms0) m_pend = 1;
        m_en = 1;
      end else if (!mask_wdata[0] && m_en) begin
        m_pend = 0; m_en = 0;
      end
      if (mask_wdata[1]) m_pend = 0;
    end
    c2hm = (c2h0 && !host_clr_c2h) || rsp_ready;
    smsb = sms0 && !host_clr_sms;
    rise = sms_set_req && !smsb;
    fall = sms_clr_req && !sms_set_req && smsb;
    if (rsp_ready && glob_irq_en && m_en) m_pend = 1;
    if (rise && sms_irq_req && glob_irq_en && m_en && !c2hm) m_pend = 1;
    if (fall && !c2hm) m_pend = 0;
    if (ctl_reset && ctl_reset_cold) begin m_pend = 0; m_en = 0; end
    m_c2h = c2hm;
    m_sms = rise ? 1'b1 : (fall ? 1'b0 : smsb);
    if (rsp_ready) m_busy = 0; else if (host_doorbell) m_busy = 1;
  endtask

  // driver: inputs are set by the caller at a falling edge
  task automatic step(input string tag);
    exp_t e;
    e.irq = m_pend;
    model_step();
    e.rd = {6'b0, m_pend, m_en};
    e.c2h = m_c2h; e.sms = m_sms; e.busy = m_busy; e.tag = tag;
    @(posedge clk);
    @(negedge clk);
    idle_inputs();
    exp_q.push_back(e);
  endtask

  task automatic wr_mask(input logic [1:0] d, input string tag);
    mask_wr = 1; mask_wdata = d; step(tag);
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        n_checks++;
        if (mask_rdata !== e.rd || host_irq !== e.irq || c2h_atn !== e.c2h ||
            sms_atn !== e.sms || ctl_busy !== e.busy) begin
          n_errors++;
          $display("FAIL %s: got rd=%02h irq=%b c2h=%b sms=%b busy=%b exp rd=%02h irq=%b c2h=%b sms=%b busy=%b",
                   e.tag, mask_rdata, host_irq, c2h_atn, sms_atn, ctl_busy,
                   e.rd, e.irq, e.c2h, e.sms, e.busy);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog: got hung run exp completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    exp_t r;
    idle_inputs();
    glob_irq_en = 1;
    rst_n = 0;
    m_en = 0; m_pend = 0; m_c2h = 0; m_sms = 0; m_busy = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    r.rd = 8'h00; r.irq = 0; r.c2h = 0; r.sms = 0; r.busy = 0; r.tag = "R1 reset state";
    exp_q.push_back(r);

    wr_mask(2'b01, "R2 enable without attention");
    host_doorbell = 1; step("R5 doorbell sets busy");
    rsp_ready = 1; step("R5 response sets pending");
    step("R9 line follows pending");
    wr_mask(2'b11, "R4 acknowledge clears pending");
    wr_mask(2'b11, "R4 acknowledge with nothing pending");
    rsp_ready = 1; step("R5 second response re-pends");
    wr_mask(2'b00, "R3 disable clears pending");
    wr_mask(2'b00, "R3 same enable value no change");
    wr_mask(2'b01, "R2 enable with attention set");
    host_clr_c2h = 1; step("R10 clear c2h keeps pending");
    wr_mask(2'b11, "R4 acknowledge");
    sms_set_req = 1; sms_irq_req = 1; step("R6 sms rise pends");
    sms_set_req = 1; sms_irq_req = 1; step("R6 matching set ignored");
    sms_clr_req = 1; step("R7 sms fall clears pending");
    sms_set_req = 1; sms_irq_req = 0; step("R6 no interrupt requested");
    host_clr_sms = 1; step("R10 clear sms keeps mask");
    rsp_ready = 1; step("R5 response pends");
    wr_mask(2'b11, "R4 acknowledge");
    sms_set_req = 1; sms_irq_req = 1; step("R6 suppressed while c2h set");
    rsp_ready = 1; step("R5 re-pend");
    sms_clr_req = 1; step("R7 sms fall kept while c2h set");
    ctl_reset = 1; step("R8 warm reset keeps mask");
    ctl_reset = 1; ctl_reset_cold = 1; step("R8 cold reset clears mask");
    step("R9 line drops after pending");
    glob_irq_en = 0;
    wr_mask(2'b01, "R2 enable ignores global enable");
    wr_mask(2'b11, "R4 acknowledge");
    rsp_ready = 1; step("R5 global disable blocks pending");
    host_clr_c2h = 1; step("R10 clear c2h");
    sms_set_req = 1; sms_irq_req = 1; step("R6 global disable blocks sms");
    repeat (2) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule